// File: doc/BRIEF.md
# Rolling-Shutter Row Control Sequencer

This block drives the per-row digital controls of a rolling-shutter pixel matrix. The matrix has 928 rows, arranged as 58 groups of 16 rows. The sequencer runs from an 80 MHz clock and visits the rows in ascending order, spending 16 clocks on each row, which gives a 200 ns row slot. For the row being read it produces four signals:

- a select enable that lasts one slot;
- a power enable that lasts two slots and opens one slot early, so the pixel can settle;
- a group power enable that stays high across all 16 slots of the row's group;
- a three-clock clamp pulse near the end of the slot, used for in-pixel correlated double sampling.

A start request opens a lead-in slot. During that slot only row 0 is powered. Continuous scanning follows, and the sequence wraps from the last row back to row 0. A one-clock marker flags the first clock of row 0 in every frame. A stop request is held until the current slot ends, and then every enable falls.

Top module: `row_sequencer`

## Requirements
- R1: After reset, every enable vector is all zero, the frame marker is low and the row index output is 0.
- R2: A start request seen in idle is followed by a lead-in slot of 16 clocks. In that slot only bit 0 of the power vector is high and no select, group or clamp bit is set. Select of row 0 begins on the next clock.
- R3: While scanning, exactly one select bit is high, for the 16 clocks of its slot. Rows follow in ascending order, and the row index output equals the selected row.
- R4: The power bit of row r is high during the slot before row r and during row r's own slot, 32 clocks in all. At most two power bits are high at any clock. During the slot of row 927, bit 0 is high as well.
- R5: While scanning, exactly one group bit is high. Bit g stays high across the 256 clocks of rows 16g to 16g+15.
- R6: The clamp bit of the selected row is high on clocks 13, 14 and 15 of its slot (counting from 0) and low on every other clock.
- R7: After row 927 the scan returns to row 0. The frame marker is high for exactly the first clock of row 0's slot, in every frame including the first.
- R8: A stop request while active takes effect at the end of the current slot. All enables and the frame marker are then low and the row index is 0. A stop request in idle has no effect.
- R9: A start request while scanning has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Row timing clock (80 MHz nominal) |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Begin scanning (used in idle only) |
| stopReq | input | 1 | Halt at the end of the current row slot |
| rowIdx | output | 10 | Index of the selected row, 0 when not scanning |
| rowSel | output | 928 | Per-row select enables |
| rowPwr | output | 928 | Per-row power enables |
| grpPwr | output | 58 | Per-group power enables |
| rowClamp | output | 928 | Per-row clamp pulse |
| frameStart | output | 1 | One-clock marker at the start of row 0 |

## Verification
At the end of the slot of row 927, a wrap to row 0 with its frame marker can land on the same clock as the ending of a pending stop. The bench scans a full frame, pulses stop in the middle of row 927's slot, and checks two things. Row 927 keeps its select through clock 15. On the following clocks no frame marker and no row 0 select appear, and every enable stays low. A second, earlier stop in the middle of row 1 compares the same slot-end logic against a plain advance, and a start pulse in the middle of a slot shows that requests seen while scanning are ignored.

// File: rtl/rowseq_pkg.sv
package rowseq_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_LEAD = 2'd1,
    MODE_RUN  = 2'd2
  } seqMode_e;

  // Strobes from the control FSM to the row datapath
  typedef struct packed {
    logic leadOn;   // lead-in slot active (row 0 powering up)
    logic selOn;    // scanning: a row is selected
    logic clampOn;  // clamp window within the current slot
    logic enter;    // last clock of lead-in, scanning begins next
    logic step;     // last clock of a slot, advance to next row
    logic halt;     // last clock of a slot, return to idle
  } rowStrobe_t;

endpackage

// File: rtl/rowseq_ctrl.sv
module rowseq_ctrl
  import rowseq_pkg::*;
#(
  parameter int CLKS_PER_ROW = 16,
  parameter int CLAMP_FIRST  = 13,
  parameter int CLAMP_LEN    = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       stopReq,
  output rowStrobe_t strb
);

  localparam int CNT_W = $clog2(CLKS_PER_ROW);
  localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(CLKS_PER_ROW - 1);
  localparam logic [CNT_W-1:0] CLAMP_LO  = CNT_W'(CLAMP_FIRST);
  localparam logic [CNT_W-1:0] CLAMP_HI  = CNT_W'(CLAMP_FIRST + CLAMP_LEN - 1);

  seqMode_e        mode, modeNext;
  logic [CNT_W-1:0] clkCnt;
  logic            stopPend;
  logic            slotEnd;
  logic            stopping;

  assign slotEnd  = (clkCnt == SLOT_LAST);
  assign stopping = stopPend | stopReq;

  always_comb begin
    modeNext = mode;
    unique case (mode)
      MODE_IDLE: if (startReq) modeNext = MODE_LEAD;
      MODE_LEAD: if (slotEnd)  modeNext = stopping ? MODE_IDLE : MODE_RUN;
      MODE_RUN:  if (slotEnd && stopping) modeNext = MODE_IDLE;
      default:   modeNext = MODE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode     <= MODE_IDLE;
      clkCnt   <= '0;
      stopPend <= 1'b0;
    end else begin
      mode     <= modeNext;
      stopPend <= (mode != MODE_IDLE) && !slotEnd && stopping;
      if (mode == MODE_IDLE || slotEnd) clkCnt <= '0;
      else                              clkCnt <= clkCnt + 1'b1;
    end
  end

  always_comb begin
    strb.leadOn  = (mode == MODE_LEAD);
    strb.selOn   = (mode == MODE_RUN);
    strb.clampOn = (mode == MODE_RUN) && (clkCnt >= CLAMP_LO) && (clkCnt <= CLAMP_HI);
    strb.enter   = (mode == MODE_LEAD) && slotEnd && !stopping;
    strb.step    = (mode == MODE_RUN) && slotEnd && !stopping;
    strb.halt    = (mode != MODE_IDLE) && slotEnd && stopping;
  end

  // R2
  leadBeforeSel_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.selOn) |-> $past(strb.leadOn));

  // R6
  clampHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.clampOn) |=> strb.clampOn);

  // R8
  haltIdle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.halt |=> (mode == MODE_IDLE) && !strb.selOn && !strb.leadOn);

  // R9
  runKeep_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.selOn && !slotEnd |=> strb.selOn && (clkCnt == $past(clkCnt) + 1'b1));

endmodule

// File: rtl/rowseq_datapath.sv
module rowseq_datapath
  import rowseq_pkg::*;
#(
  parameter int NUM_ROWS       = 928,
  parameter int ROWS_PER_GROUP = 16,
  localparam int NUM_GROUPS    = NUM_ROWS / ROWS_PER_GROUP,
  localparam int ROW_W         = $clog2(NUM_ROWS),
  localparam int GRP_W         = $clog2(NUM_GROUPS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  rowStrobe_t            strb,
  output logic [ROW_W-1:0]      rowIdx,
  output logic [NUM_ROWS-1:0]   rowSel,
  output logic [NUM_ROWS-1:0]   rowPwr,
  output logic [NUM_GROUPS-1:0] grpPwr,
  output logic [NUM_ROWS-1:0]   rowClamp,
  output logic                  frameStart
);

  localparam int SUB_W = (ROWS_PER_GROUP > 1) ? $clog2(ROWS_PER_GROUP) : 1;
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NUM_ROWS - 1);
  localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(NUM_GROUPS - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(ROWS_PER_GROUP - 1);

  logic [GRP_W-1:0] grpIdx;
  logic [SUB_W-1:0] subIdx;
  logic [ROW_W-1:0] nextIdx;
  logic             lastRow;
  logic             activeOn;

  assign lastRow  = (rowIdx == ROW_LAST);
  assign nextIdx  = lastRow ? '0 : rowIdx + 1'b1;
  assign activeOn = strb.selOn | strb.leadOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowIdx     <= '0;
      grpIdx     <= '0;
      subIdx     <= '0;
      frameStart <= 1'b0;
    end else begin
      frameStart <= strb.enter | (strb.step & lastRow);
      if (strb.halt || strb.enter) begin
        rowIdx <= '0;
        grpIdx <= '0;
        subIdx <= '0;
      end else if (strb.step) begin
        rowIdx <= nextIdx;
        if (subIdx == SUB_LAST) begin
          subIdx <= '0;
          grpIdx <= (grpIdx == GRP_LAST) ? '0 : grpIdx + 1'b1;
        end else begin
          subIdx <= subIdx + 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_rowDec
    logic isCur;
    logic isNext;
    assign isCur       = (rowIdx == ROW_W'(i));
    assign isNext      = (nextIdx == ROW_W'(i));
    assign rowSel[i]   = strb.selOn & isCur;
    assign rowPwr[i]   = (activeOn & isCur) | (strb.selOn & isNext);
    assign rowClamp[i] = strb.clampOn & isCur;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grpDec
    assign grpPwr[g] = strb.selOn & (grpIdx == GRP_W'(g));
  end

  // R3
  rowStep_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.step && !lastRow |=> rowIdx == $past(rowIdx) + 1'b1);

  // R3
  selOne_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.selOn |-> $onehot(rowSel));

  // R7
  rowWrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.step && lastRow |=> (rowIdx == '0) && frameStart);

  // R4
  pwrCount_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(rowPwr) <= 2);

  // R5
  grpOne_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.selOn |-> $onehot(grpPwr));

  // R5
  grpHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.step && (subIdx != SUB_LAST) |=> $stable(grpPwr));

  // R8
  idleQuiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !activeOn |-> (rowPwr == '0) && (rowSel == '0) && (grpPwr == '0));

endmodule

// File: rtl/row_sequencer.sv
module row_sequencer
  import rowseq_pkg::*;
#(
  parameter int NUM_ROWS       = 928,
  parameter int ROWS_PER_GROUP = 16,
  parameter int CLKS_PER_ROW   = 16,
  parameter int CLAMP_FIRST    = 13,
  parameter int CLAMP_LEN      = 3,
  localparam int NUM_GROUPS    = NUM_ROWS / ROWS_PER_GROUP,
  localparam int ROW_W         = $clog2(NUM_ROWS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startReq,
  input  logic                  stopReq,
  output logic [ROW_W-1:0]      rowIdx,
  output logic [NUM_ROWS-1:0]   rowSel,
  output logic [NUM_ROWS-1:0]   rowPwr,
  output logic [NUM_GROUPS-1:0] grpPwr,
  output logic [NUM_ROWS-1:0]   rowClamp,
  output logic                  frameStart
);

  rowStrobe_t strb;

  rowseq_ctrl #(
    .CLKS_PER_ROW(CLKS_PER_ROW),
    .CLAMP_FIRST (CLAMP_FIRST),
    .CLAMP_LEN   (CLAMP_LEN)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startReq(startReq),
    .stopReq (stopReq),
    .strb    (strb)
  );

  rowseq_datapath #(
    .NUM_ROWS      (NUM_ROWS),
    .ROWS_PER_GROUP(ROWS_PER_GROUP)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rowIdx    (rowIdx),
    .rowSel    (rowSel),
    .rowPwr    (rowPwr),
    .grpPwr    (grpPwr),
    .rowClamp  (rowClamp),
    .frameStart(frameStart)
  );

endmodule

// File: tb/tb_row_sequencer.sv
module tb_row_sequencer;

  localparam int N  = 928;
  localparam int G  = 58;
  localparam int RW = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic          stopReq = 1'b0;
  logic [RW-1:0] rowIdx;
  logic [N-1:0]  rowSel, rowPwr, rowClamp;
  logic [G-1:0]  grpPwr;
  logic          frameStart;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  row_sequencer dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq),
    .rowIdx(rowIdx), .rowSel(rowSel), .rowPwr(rowPwr), .grpPwr(grpPwr),
    .rowClamp(rowClamp), .frameStart(frameStart)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] oneRow(input int r);
    logic [N-1:0] v;
    v = '0;
    v[r] = 1'b1;
    return v;
  endfunction

  function automatic logic [G-1:0] oneGrp(input int g);
    logic [G-1:0] v;
    v = '0;
    v[g] = 1'b1;
    return v;
  endfunction

  // Check every output of one row slot, optionally pulsing start or stop at clock k
  task automatic checkSlot(input int r, input bit expFrame, input int stopAt, input int startAt);
    int eSel = 0, ePwr = 0, eGrp = 0, eClamp = 0, eFrame = 0;
    for (int k = 0; k < 16; k++) begin
      if (rowSel !== oneRow(r) || rowIdx !== RW'(r)) eSel++;
      if (rowPwr !== (oneRow(r) | oneRow((r + 1) % N))) ePwr++;
      if (grpPwr !== oneGrp(r / 16)) eGrp++;
      if (rowClamp !== ((k >= 13) ? oneRow(r) : '0)) eClamp++;
      if (frameStart !== (expFrame && k == 0)) eFrame++;
      stopReq  = (k == stopAt);
      startReq = (k == startAt);
      tick();
      stopReq  = 1'b0;
      startReq = 1'b0;
    end
    chk(eSel == 0,   $sformatf("R3 select row %0d", r), eSel, 0);
    chk(ePwr == 0,   $sformatf("R4 power row %0d", r), ePwr, 0);
    chk(eGrp == 0,   $sformatf("R5 group row %0d", r), eGrp, 0);
    chk(eClamp == 0, $sformatf("R6 clamp row %0d", r), eClamp, 0);
    chk(eFrame == 0, $sformatf("R7 marker row %0d", r), eFrame, 0);
  endtask

  task automatic checkIdle(input int cycles, input string tag);
    int errs = 0;
    for (int k = 0; k < cycles; k++) begin
      if (rowSel !== '0 || rowPwr !== '0 || grpPwr !== '0 || rowClamp !== '0 ||
          frameStart !== 1'b0 || rowIdx !== '0) errs++;
      tick();
    end
    chk(errs == 0, tag, errs, 0);
  endtask

  // R2: start pulse, lead-in slot, returns at clock 0 of row 0
  task automatic startLead();
    int errs = 0;
    startReq = 1'b1;
    tick();
    startReq = 1'b0;
    for (int k = 0; k < 16; k++) begin
      if (rowPwr !== oneRow(0) || rowSel !== '0 || grpPwr !== '0 ||
          rowClamp !== '0 || frameStart !== 1'b0) errs++;
      tick();
    end
    chk(errs == 0, "R2 lead-in slot", errs, 0);
    chk(rowSel === oneRow(0), "R2 row 0 selected after lead-in", int'(rowIdx), 0);
  endtask

  task automatic testReset();
    chk(rowSel === '0 && rowPwr === '0 && grpPwr === '0 && rowClamp === '0,
        "R1 enables clear after reset", $countones(rowPwr), 0);
    chk(frameStart === 1'b0 && rowIdx === '0, "R1 marker and index after reset",
        int'(rowIdx), 0);
  endtask

  task automatic testIdleStop();
    stopReq = 1'b1;
    tick();
    stopReq = 1'b0;
    checkIdle(8, "R8 stop in idle leaves outputs low");
  endtask

  task automatic testScanAndWrap();
    startLead();
    for (int r = 0; r < 21; r++)
      checkSlot(r, r == 0, -1, (r == 5) ? 7 : -1);  // R9 start pulse in row 5
    repeat ((926 - 21) * 16) tick();
    checkSlot(926, 1'b0, -1, -1);
    checkSlot(927, 1'b0, -1, -1);  // R4 row 0 powered during last row
    checkSlot(0, 1'b1, -1, -1);    // R7 wrap with marker
    checkSlot(1, 1'b0, 5, -1);     // R8 stop mid-slot, row 1 completes
    checkIdle(20, "R8 all enables low after stop");
  endtask

  task automatic testStopAtWrap();
    startLead();
    checkSlot(0, 1'b1, -1, -1);
    repeat ((927 - 1) * 16) tick();
    checkSlot(927, 1'b0, 4, -1);
    checkIdle(20, "R7 R8 no wrap or marker after stop in last row");
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    rstN = 1'b1;
    tick();
    testReset();
    testIdleStop();
    testScanAndWrap();
    testStopAtWrap();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule